// File: doc/BRIEF.md
# I2C EEPROM Target

This block is the bus-facing side of a small serial memory. It watches an already synchronised I2C clock and data pair, recognises START and STOP, decodes a select byte and a one-byte word address, and then either takes data bytes into a row-sized staging buffer or streams bytes back out of an internal byte array. It acknowledges by pulling SDA low through a single pull-low enable output. The chip's pad logic turns that output into an open-drain driver.

Writes are held in the staging buffer until the master sends STOP. The buffered bytes are then copied into the array, and a busy timer models the slow programming cycle. While that timer runs, the target ignores its own select code, so a master can poll with select bytes until one is acknowledged. A write-inhibit input lets the system freeze the contents. Writes are still acknowledged byte by byte, but nothing is stored and no busy cycle starts.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the SDA pull-low output and busy output are 0, and every byte of the array reads back as 0x00.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Data is sampled on SCL rising edges, and the pull-low output only changes while SCL is low.
- R3: The first byte after START is decoded MSB first. Bits 7:4 must equal 4'b1010, bits 3:1 are ignored, and bit 0 selects read (1) or write (0). A matching byte is acknowledged by pulling SDA low during the 9th clock. A non-matching byte is not acknowledged, and every later byte up to the next START or STOP is ignored.
- R4: After a write select, the next byte is acknowledged and loads the address pointer.
- R5: A single data byte followed by STOP is stored at the pointed address. The busy output then goes high for WRITE_CYCLES clock cycles, starting in the cycle after STOP is seen.
- R6: A page write accepts any number of data bytes and acknowledges each one. Only the low 3 address bits advance, wrapping inside the 8-byte row, so a 9th byte replaces the first. After STOP the pointer holds the row location that follows the last byte written.
- R7: While the write-inhibit input is high at STOP, the data bytes are still acknowledged but the array is left unchanged and busy stays low.
- R8: While busy is high, a matching select byte is not acknowledged.
- R9: A read select returns the byte at the pointer, MSB first, and increments the pointer after each byte, wrapping from the top of the array to 0. Reading continues while the master acknowledges. After a master NACK the target releases SDA until the next START or STOP.
- R10: A repeated START returns the decoder to the select-byte state and discards buffered write data that no STOP has committed, while the pointer keeps the address just loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample SCL and SDA |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA bus level |
| wr_inhibit_i | input | 1 | High blocks commits to the array |
| sda_pull_o | output | 1 | High pulls SDA low (acknowledge or read data 0) |
| busy_o | output | 1 | High while the internal write cycle runs |

## Verification
The bench builds the block with a 256-byte array, 8-byte rows and WRITE_CYCLES set to 300. With that timer length, a select byte sent straight after a write lands inside the busy window, and the length of the busy pulse can be measured exactly. The 256-byte array puts the top-of-array wrap of a sequential read at 0xFF to 0x00, where a short read starting at 0xFE reaches it. Random page writes of 1 to 9 bytes at random offsets exercise the in-row wrap from every starting column and are checked against a bench model of the array.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int MEM_BYTES    = 256,
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 1000,
  parameter logic [3:0] TYPE_ID = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wr_inhibit_i,
  output logic sda_pull_o,
  output logic busy_o
);
  localparam int AW   = $clog2(MEM_BYTES);
  localparam int COLW = $clog2(PAGE_BYTES);
  localparam int ROWW = AW - COLW;
  localparam int CW   = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0, ST_DEV = 3'd1, ST_ADDR = 3'd2, ST_WDATA = 3'd3,
    ST_ACK = 3'd4, ST_RDATA = 3'd5, ST_SKIP = 3'd6
  } state_t;

  state_t              state, after_ack;
  logic                scl_q, sda_q;
  logic [3:0]          bitcnt;
  logic [7:0]          shreg;
  logic [AW-1:0]       ptr;
  logic [ROWW-1:0]     row;
  logic [COLW-1:0]     col;
  logic [7:0]          pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic [7:0]          mem [MEM_BYTES];
  logic [CW-1:0]       busy_cnt;
  logic                rd_ack;

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire commit   = stop_c & (|pmask) & ~wr_inhibit_i;

  assign busy_o     = (busy_cnt != '0);
  assign sda_pull_o = (state == ST_ACK) |
                      ((state == ST_RDATA) && (bitcnt < 4'd8) && !shreg[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pmask[i]) mem[{row, COLW'(i)}] <= pbuf[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      state     <= ST_IDLE;
      after_ack <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      ptr       <= '0;
      row       <= '0;
      col       <= '0;
      pmask     <= '0;
      busy_cnt  <= '0;
      rd_ack    <= 1'b0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'h00;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (commit)        busy_cnt <= CW'(WRITE_CYCLES);
      else if (busy_o)   busy_cnt <= busy_cnt - 1'b1;

      if (start_c) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        pmask  <= '0;
      end else if (stop_c) begin
        state <= ST_IDLE;
        pmask <= '0;
        if (|pmask) ptr <= {row, col};
      end else begin
        case (state)
          ST_DEV, ST_ADDR, ST_WDATA: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_i};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              case (state)
                ST_DEV: begin
                  if (shreg[7:4] == TYPE_ID && !busy_o) begin
                    state     <= ST_ACK;
                    after_ack <= shreg[0] ? ST_RDATA : ST_ADDR;
                  end else begin
                    state <= ST_SKIP;
                  end
                end
                ST_ADDR: begin
                  ptr       <= shreg[AW-1:0];
                  row       <= shreg[AW-1:COLW];
                  col       <= shreg[COLW-1:0];
                  state     <= ST_ACK;
                  after_ack <= ST_WDATA;
                end
                default: begin
                  pbuf[col]  <= shreg;
                  pmask[col] <= 1'b1;
                  col        <= col + 1'b1;
                  state      <= ST_ACK;
                  after_ack  <= ST_WDATA;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state  <= after_ack;
              bitcnt <= '0;
              if (after_ack == ST_RDATA) begin
                shreg <= mem[ptr];
                ptr   <= ptr + 1'b1;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise && bitcnt == 4'd8) rd_ack <= ~sda_i;
            if (scl_fall) begin
              if (bitcnt < 4'd8) begin
                bitcnt <= bitcnt + 4'd1;
                shreg  <= {shreg[6:0], 1'b1};
              end else if (rd_ack) begin
                bitcnt <= '0;
                shreg  <= mem[ptr];
                ptr    <= ptr + 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module i2c_eeprom_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       wr_inhibit_i,
  input logic       sda_pull_o,
  input logic       busy_o,
  input logic [2:0] st,
  input logic [3:0] dev_type
);
  localparam logic [2:0] S_DEV = 3'd1;
  localparam logic [2:0] S_ACK = 3'd4;

  AST_PULL_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_pull_o)); // R2
  AST_SELECT_TYPE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK && $past(st) == S_DEV) |-> $past(dev_type) == 4'b1010); // R3
  AST_NO_SELECT_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK && $past(st) == S_DEV) |-> !$past(busy_o)); // R8
  AST_INHIBIT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !$past(wr_inhibit_i)); // R7
  AST_CYCLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(scl_i)); // R5
endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .wr_inhibit_i(wr_inhibit_i),
  .sda_pull_o(sda_pull_o), .busy_o(busy_o), .st(state), .dev_type(shreg[7:4])
);

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
  localparam int WCYC = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, inhibit = 1'b0;
  logic sda_pull, busy;
  wire  sda_bus = m_sda & ~sda_pull;

  int checks = 0, fails = 0;
  logic [7:0] model [256];
  logic [7:0] mptr;
  logic [7:0] wdat [16];

  always #4 clk = ~clk;

  i2c_eeprom_target #(.MEM_BYTES(256), .PAGE_BYTES(8), .WRITE_CYCLES(WCYC)) i_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .wr_inhibit_i(inhibit), .sda_pull_o(sda_pull), .busy_o(busy));

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; tick(1); m_scl = 1'b1; tick(2);
    m_sda = 1'b0; tick(2); m_scl = 1'b0; tick(1);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; tick(1); m_scl = 1'b1; tick(2);
    m_sda = 1'b1; tick(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(1); m_scl = 1'b1; tick(2); m_scl = 1'b0; tick(1);
    end
    m_sda = 1'b1; tick(1); m_scl = 1'b1; tick(1);
    ack = !sda_bus; tick(1); m_scl = 1'b0; tick(1);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b, output int glitch);
    logic s1;
    glitch = 0;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(1); m_scl = 1'b1; tick(1); s1 = sda_bus; tick(1);
      b[i] = sda_bus; if (s1 != sda_bus) glitch++;
      m_scl = 1'b0;
    end
    tick(1); m_sda = !give_ack; tick(1); m_scl = 1'b1; tick(2);
    m_scl = 1'b0; tick(1); m_sda = 1'b1;
  endtask

  function automatic logic [7:0] sel(input bit rd);
    return {4'b1010, 3'($urandom_range(0, 7)), rd};
  endfunction

  function automatic logic [7:0] next_ptr(input logic [7:0] a, input int n);
    return {a[7:3], 3'(a[2:0] + n)};
  endfunction

  task automatic wait_idle;
    while (busy) tick(1);
  endtask

  task automatic do_write(input logic [7:0] a, input int n, input bit wait_done);
    bit ack;
    i2c_start();
    send_byte(sel(1'b0), ack); check(ack, "R3 write select ack", ack, 1);
    send_byte(a, ack);         check(ack, "R4 address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wdat[k], ack); check(ack, "R6 data ack", ack, 1);
      if (!inhibit) model[next_ptr(a, k)] = wdat[k];
    end
    i2c_stop();
    mptr = next_ptr(a, n);
    if (wait_done) wait_idle();
  endtask

  task automatic do_read(input bit set_addr, input logic [7:0] a, input int n);
    bit ack;
    logic [7:0] b;
    int g;
    i2c_start();
    if (set_addr) begin
      send_byte(sel(1'b0), ack); check(ack, "R10 select before restart", ack, 1);
      send_byte(a, ack);         check(ack, "R4 address ack", ack, 1);
      mptr = a;
      i2c_start();
    end
    send_byte(sel(1'b1), ack); check(ack, "R9 read select ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b, g);
      check(b == model[mptr], "R9 read data", b, model[mptr]);
      check(g == 0, "R2 data stable while SCL high", g, 0);
      mptr = mptr + 8'd1;
    end
    i2c_stop();
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    int g, cnt;
    void'($urandom(32'h1c2e));
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    mptr = 8'h00;
    tick(3); rst_n = 1'b1; tick(2);

    check(sda_pull == 1'b0, "R1 pull released after reset", sda_pull, 0);
    check(busy == 1'b0, "R1 busy low after reset", busy, 0);
    do_read(1'b1, 8'h55, 2);

    wdat[0] = 8'hA5;
    do_write(8'h10, 1, 1'b0);
    check(busy == 1'b1, "R5 busy after STOP", busy, 1);
    cnt = 0;
    while (busy) begin cnt++; tick(1); end
    check(cnt >= WCYC - 2 && cnt <= WCYC, "R5 busy length", cnt, WCYC);
    do_read(1'b1, 8'h10, 1);

    i2c_start();
    send_byte(8'hB0, ack); check(!ack, "R3 wrong type not acked", ack, 0);
    send_byte(8'h12, ack); check(!ack, "R3 later byte ignored", ack, 0);
    i2c_stop();

    wdat[0] = 8'h5A;
    do_write(8'h11, 1, 1'b0);
    i2c_start();
    send_byte(sel(1'b0), ack); check(!ack, "R8 select refused while busy", ack, 0);
    i2c_stop();
    wait_idle();
    i2c_start();
    send_byte(sel(1'b0), ack); check(ack, "R8 select accepted after cycle", ack, 1);
    i2c_stop();

    for (int k = 0; k < 9; k++) wdat[k] = 8'h30 + 8'(k);
    do_write(8'h2D, 9, 1'b1);
    check(model[8'h2D] == 8'h38, "R6 ninth byte replaced first", model[8'h2D], 8'h38);
    do_read(1'b1, 8'h27, 10);
    do_write(8'h2D, 0, 1'b1);
    wdat[0] = 8'hC3; wdat[1] = 8'h3C;
    do_write(8'h4E, 2, 1'b1);
    do_read(1'b0, 8'h00, 1);

    inhibit = 1'b1;
    wdat[0] = 8'hFF;
    do_write(8'h10, 1, 1'b0);
    tick(2);
    check(busy == 1'b0, "R7 no write cycle when inhibited", busy, 0);
    inhibit = 1'b0;
    do_read(1'b1, 8'h10, 1);

    i2c_start();
    send_byte(sel(1'b0), ack); check(ack, "R10 select", ack, 1);
    send_byte(8'h40, ack);     check(ack, "R10 address", ack, 1);
    send_byte(8'h77, ack);     check(ack, "R10 data ack", ack, 1);
    i2c_start();
    send_byte(sel(1'b1), ack); check(ack, "R10 restart read select", ack, 1);
    recv_byte(1'b0, b, g);
    check(b == model[8'h40], "R10 pending data discarded", b, model[8'h40]);
    i2c_stop();
    check(busy == 1'b0, "R10 no write cycle after discard", busy, 0);
    mptr = 8'h41;

    model[8'hFF] = 8'h00;
    wdat[0] = 8'h9E; wdat[1] = 8'hE9;
    do_write(8'hFE, 2, 1'b1);
    wdat[0] = 8'h01;
    do_write(8'h00, 1, 1'b1);
    do_read(1'b1, 8'hFE, 3);

    i2c_start();
    send_byte(sel(1'b1), ack); check(ack, "R9 select", ack, 1);
    recv_byte(1'b0, b, g);
    check(b == model[mptr], "R9 byte before NACK", b, model[mptr]);
    recv_byte(1'b0, b, g);
    check(b == 8'hFF, "R9 released after NACK", b, 8'hFF);
    i2c_stop();

    for (int it = 0; it < 20; it++) begin
      logic [7:0] a;
      int n;
      a = 8'($urandom);
      n = $urandom_range(1, 9);
      for (int k = 0; k < n; k++) wdat[k] = 8'($urandom);
      do_write(a, n, 1'b1);
      do_read(1'b1, {a[7:3], 3'b000}, 8);
    end

    report();
  end
endmodule